// File: doc/BRIEF.md
# Saturating Up/Down Wiper Position Counter

This block is the digital control core of a 128-step digitally controlled resistor. It keeps a wiper position that starts at midscale. The position moves one step for each clean falling edge of a step strobe, but only while the active-low select input is held low. A direction input chooses whether the step goes up or down. The position stops at either end of its range and never wraps.

The select, direction and strobe inputs may be asynchronous to the system clock, so each one passes through a synchroniser before it is used. A falling edge is recognised when a synchronised high sample is followed by a synchronised low sample. The direction and select values used for the step are the synchronised values in the cycle in which that edge is recognised. The position is also decoded, with no added register, into a one-hot tap select that switches the resistor string. A flag reports when the position sits at either end.

Top module: `step_wiper_core`

## Requirements
- R1: After reset the position `pos` is 64 (midscale, 40H), `tap_sel` has only bit 64 set, and `at_end` is 0.
- R2: A falling edge of `step_clk` while `sel_n` is low changes `pos` by exactly one: +1 when `dir_up` is 1, -1 when `dir_up` is 0.
- R3: Falling edges of `step_clk` while `sel_n` is high leave `pos` unchanged.
- R4: When `pos` is 127 (all ones, full scale), further up steps leave it at 127; it never wraps to 0.
- R5: When `pos` is 0, further down steps leave it at 0; it never wraps to 127.
- R6: `tap_sel` always has exactly one bit set, and the index of that bit equals `pos` in the same cycle.
- R7: `at_end` is 1 exactly when `pos` is 0 or 127.
- R8: One falling edge gives exactly one step however long `step_clk` stays low afterwards, and a rising edge gives no step.
- R9: With two synchroniser stages, `pos` changes on the third rising `clk` edge after `step_clk` falls, and the `sel_n` and `dir_up` values used are those sampled together with the low strobe level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to midscale |
| sel_n | input | 1 | Active-low select; steps are taken only while it is low |
| dir_up | input | 1 | Step direction: 1 counts up, 0 counts down |
| step_clk | input | 1 | Step strobe; each falling edge requests one step |
| pos | output | 7 | Current wiper position |
| tap_sel | output | 128 | One-hot wiper tap select, bit index equal to `pos` |
| at_end | output | 1 | High while the position is at 0 or at 127 |

## Verification
The bench builds the block with a 7-bit position and two synchroniser stages, the default values. With 128 positions, a run of 70 up steps from midscale and 140 down steps crosses both ends and hammers each saturation point with more edges than it can take. The two-stage setting makes the three-edge latency from strobe fall to position change a fixed number, so the bench can check it directly and compare against its reference model on every clock.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  // Synchronised control bundle; field order is internal only
  typedef struct packed {
    logic sel_n;
    logic up;
    logic step;
  } wiper_ctl_t;

  // Idle levels loaded into every synchroniser stage at reset
  localparam wiper_ctl_t CTL_IDLE = '{sel_n: 1'b1, up: 1'b0, step: 1'b1};

endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/wiper_edge.sv
module wiper_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fall
);

  logic lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b1;
    else        lvl_d <= lvl;
  end

  // Previous sample high, present sample low
  assign fall = lvl_d & ~lvl;

endmodule

// File: rtl/wiper_counter.sv
module wiper_counter #(
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             up,
  output logic [POS_W-1:0] pos
);

  localparam logic [POS_W-1:0] TOP_POS = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] MID_POS = {1'b1, {(POS_W-1){1'b0}}};

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= MID_POS;
    end else if (step_en) begin
      if (up && pos_q != TOP_POS)
        pos_q <= pos_q + 1'b1;
      else if (!up && pos_q != '0)
        pos_q <= pos_q - 1'b1;
    end
  end

  assign pos = pos_q;

endmodule

// File: rtl/wiper_decode.sv
module wiper_decode #(
  parameter int POS_W = 7,
  localparam int NTAPS = 1 << POS_W
) (
  input  logic [POS_W-1:0] pos,
  output logic [NTAPS-1:0] tap_sel,
  output logic             at_end
);

  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    assign tap_sel[i] = (pos == i[POS_W-1:0]);
  end

  // End flag taken from the two outermost taps
  assign at_end = tap_sel[0] | tap_sel[NTAPS-1];

endmodule

// File: rtl/step_wiper_core.sv
module step_wiper_core #(
  parameter int POS_W       = 7,
  parameter int SYNC_STAGES = 2,
  localparam int NTAPS      = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             dir_up,
  input  logic             step_clk,
  output logic [POS_W-1:0] pos,
  output logic [NTAPS-1:0] tap_sel,
  output logic             at_end
);
  import wiper_pkg::*;

  localparam int CTL_W = $bits(wiper_ctl_t);

  wiper_ctl_t ctl_raw;
  wiper_ctl_t ctl_s;
  logic       step_fall;
  logic       sel_act;

  assign ctl_raw = '{sel_n: sel_n, up: dir_up, step: step_clk};

  wiper_sync #(
    .W      (CTL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(CTL_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ctl_raw),
    .q    (ctl_s)
  );

  wiper_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (ctl_s.step),
    .fall (step_fall)
  );

  assign sel_act = ~ctl_s.sel_n;

  wiper_counter #(.POS_W(POS_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_en(step_fall & sel_act),
    .up     (ctl_s.up),
    .pos    (pos)
  );

  wiper_decode #(.POS_W(POS_W)) u_dec (
    .pos    (pos),
    .tap_sel(tap_sel),
    .at_end (at_end)
  );

endmodule

// File: rtl/wiper_chk.sv
module wiper_chk #(
  parameter int POS_W = 7,
  localparam int NTAPS = 1 << POS_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [POS_W-1:0] pos,
  input logic [NTAPS-1:0] tap_sel,
  input logic             at_end,
  input logic             fall,
  input logic             sel_ok
);

  localparam logic [POS_W-1:0] TOP_POS = {POS_W{1'b1}};

  // R2
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos != $past(pos) |-> (pos == $past(pos) + 1'b1 || pos == $past(pos) - 1'b1));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall && sel_ok) |=> $stable(pos));

  // R4
  top_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos == TOP_POS |=> pos != '0);

  // R5
  bottom_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos == '0 |=> pos != TOP_POS);

  // R6
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1 && tap_sel[pos]);

  // R7
  end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_end == (pos == '0 || pos == TOP_POS));

endmodule

bind step_wiper_core wiper_chk #(.POS_W(POS_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .pos    (pos),
  .tap_sel(tap_sel),
  .at_end (at_end),
  .fall   (step_fall),
  .sel_ok (sel_act)
);

// File: tb/step_wiper_core_test.sv
module step_wiper_core_test;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 7;
  localparam int NT = 1 << PW;
  localparam int TOPV = NT - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic dir_up = 1'b0;
  logic step_clk = 1'b1;
  logic [PW-1:0] pos;
  logic [NT-1:0] tap_sel;
  logic at_end;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  step_wiper_core uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .dir_up(dir_up),
    .step_clk(step_clk), .pos(pos), .tap_sel(tap_sel), .at_end(at_end)
  );

  task automatic chk(input bit ok, input string req, input logic [NT-1:0] act,
                     input logic [NT-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model: history of input samples, bit2=sel_n bit1=dir bit0=step
  logic [2:0] hist [$];
  int mpos = NT / 2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpos = NT / 2;
      hist = {3'b101, 3'b101, 3'b101};
    end else begin
      // hist[1] = inputs two edges ago, hist[2] = three edges ago
      if (hist[2][0] && !hist[1][0] && !hist[1][2]) begin
        if (hist[1][1]) begin
          if (mpos < TOPV) mpos++;
        end else begin
          if (mpos > 0) mpos--;
        end
      end
      hist.push_front({sel_n, dir_up, step_clk});
      void'(hist.pop_back());
    end
  end

  // Every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(pos == mpos[PW-1:0], "R2 pos vs model", NT'(pos), NT'(mpos));
      chk(tap_sel == (NT'(1) << mpos), "R6 tap_sel vs model", tap_sel, NT'(1) << mpos);
      chk(at_end == (mpos == 0 || mpos == TOPV), "R7 at_end vs model",
          NT'(at_end), NT'(mpos == 0 || mpos == TOPV));
    end
  end

  task automatic steps(input int n, input bit up, input bit seln, input int low_len);
    @(negedge clk);
    dir_up = up;
    sel_n = seln;
    repeat (3) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      step_clk = 1'b0;
      repeat (low_len) @(negedge clk);
      step_clk = 1'b1;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] p0;
    repeat (3) @(negedge clk);
    // R1 reset state (checked while held in reset)
    chk(pos == 7'd64, "R1 reset pos", NT'(pos), NT'(64));
    chk(tap_sel == (NT'(1) << 64), "R1 reset tap_sel", tap_sel, NT'(1) << 64);
    chk(at_end == 1'b0, "R1 reset at_end", NT'(at_end), NT'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 up and down single steps
    steps(3, 1'b1, 1'b0, 4);
    chk(pos == 7'd67, "R2 three up steps", NT'(pos), NT'(67));
    steps(5, 1'b0, 1'b0, 4);
    chk(pos == 7'd62, "R2 five down steps", NT'(pos), NT'(62));

    // R3 edges with select high
    steps(6, 1'b1, 1'b1, 4);
    chk(pos == 7'd62, "R3 deselected up edges", NT'(pos), NT'(62));
    steps(6, 1'b0, 1'b1, 4);
    chk(pos == 7'd62, "R3 deselected down edges", NT'(pos), NT'(62));

    // R8 long low time, one step; rising edge no step
    steps(1, 1'b1, 1'b0, 25);
    chk(pos == 7'd63, "R8 long low one step", NT'(pos), NT'(63));

    // R9 latency: change on third rising edge
    p0 = pos;
    @(negedge clk);
    step_clk = 1'b0;
    repeat (2) @(negedge clk);
    chk(pos == p0, "R9 no change after two edges", NT'(pos), NT'(p0));
    @(negedge clk);
    chk(pos == p0 + 1'b1, "R9 change after third edge", NT'(pos), NT'(p0 + 1'b1));
    step_clk = 1'b1;
    repeat (4) @(negedge clk);

    // R4 saturate at top
    steps(70, 1'b1, 1'b0, 3);
    chk(pos == 7'd127, "R4 hold at full scale", NT'(pos), NT'(127));
    chk(at_end == 1'b1, "R7 at_end at top", NT'(at_end), NT'(1));
    chk(tap_sel == (NT'(1) << 127), "R6 top tap", tap_sel, NT'(1) << 127);

    // R5 saturate at bottom
    steps(140, 1'b0, 1'b0, 3);
    chk(pos == 7'd0, "R5 hold at zero", NT'(pos), NT'(0));
    chk(at_end == 1'b1, "R7 at_end at bottom", NT'(at_end), NT'(1));
    chk(tap_sel == NT'(1), "R6 bottom tap", tap_sel, NT'(1));

    // R9 direction sampled with edge: flip dir only while strobe high
    steps(2, 1'b1, 1'b0, 4);
    chk(pos == 7'd2, "R9 up after bottom", NT'(pos), NT'(2));
    chk(at_end == 1'b0, "R7 at_end off interior", NT'(at_end), NT'(0));

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule